// File: doc/BRIEF.md
# Instruction Scratchpad Copy Controller

This block fills a tagless instruction scratchpad while the program is running. Software places a special load-scratchpad instruction in the code. When the processor executes it, the processor passes the instruction's operand to this controller as a command index. The index selects an entry in a small table of basic-block descriptors. Each descriptor names a source word address in main instruction memory, a destination word offset in the scratchpad, a length in words and a flag that marks the end of a chain. Starting at the indexed entry, the controller walks consecutive descriptors until it reaches one whose end flag is set, and copies each block one word at a time.

The processor is stalled for the whole copy. The scratchpad therefore needs no tags and no hit/miss logic, because software decides in advance which fetches come from the scratchpad and which come from main memory. Reads go out on a valid/ready request port and come back on a response strobe after a variable number of cycles. Each returned word is written into the scratchpad in the cycle it arrives. The descriptor table is loaded through its own programming port. Writes to that port take effect only while the controller is idle.

Top module: `ispm_copy_ctrl`

## Requirements
- R1: A command is accepted only while the controller is idle (stall and done both low). The stall output is high in the cycle after the command is accepted.
- R2: Each descriptor holds a source word address, a destination scratchpad offset, a length and an end flag. A command processes descriptors in ascending index order, starting at the command index. Past the last table slot the index wraps to 0. Processing stops after the first descriptor whose end flag is set.
- R3: For a descriptor with length L, scratchpad word (dst+k) mod scratchpad size receives main-memory word (src+k) mod memory size, for k = 0..L-1. When two blocks overlap in the scratchpad, the later write wins.
- R4: At most one memory read is outstanding. A request is held with an unchanged address until it is accepted. Every scratchpad write happens in the cycle its response arrives and carries that response's data.
- R5: Stall stays high from the cycle after acceptance until the cycle after the last scratchpad write. With the request always accepted and responses arriving in the next cycle, stall lasts the sum over visited descriptors of (1 + 2 × length) cycles.
- R6: A descriptor with length zero causes no memory request. If that descriptor also has its end flag set, the sequence ends at once, with stall high for a single cycle.
- R7: Done is a one-cycle pulse in the cycle stall falls. In the cycle after done, the controller is idle again and accepts a new command.
- R8: Table writes take effect when the controller is idle. Table writes made while stall or done is high are ignored.
- R9: A command that arrives while stall or done is high is ignored and sets the busy-error output. Busy-error stays set until reset.
- R10: During and after reset, stall, done, busy-error, the memory request and the scratchpad write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load-scratchpad instruction executed this cycle |
| cmd_idx | input | 3 | Instruction operand: first descriptor index |
| stall | output | 1 | Hold the processor |
| done | output | 1 | One-cycle pulse when a sequence ends |
| busy_err | output | 1 | Sticky flag: command received while busy |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | 3 | Descriptor index to write |
| tbl_src | input | 12 | Source word address in main memory |
| tbl_dst | input | 6 | Destination scratchpad word offset |
| tbl_len | input | 5 | Block length in words |
| tbl_last | input | 1 | End-of-chain flag |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 12 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 16 | Read data |
| spm_we | output | 1 | Scratchpad write enable |
| spm_addr | output | 6 | Scratchpad word address |
| spm_data | output | 16 | Scratchpad write data |

## Verification
The assertions assume that the memory side never raises a response strobe unless a read has been accepted and is still unanswered, and that it returns exactly one response per accepted read. The bench's memory model meets this by construction. It records a request only on a valid-and-ready cycle and answers it once, either in the next cycle or after a delay of 0 to 3 extra cycles taken from the address. Its ready line follows a fixed pattern. Commands and table writes are driven away from the clock edge. During a busy window they are raised on purpose, so that the error path and the table-write lockout are exercised.

// File: rtl/isc_pkg.sv
package isc_pkg;

    // datapath widths
    localparam int DATA_W = 16;
    localparam int MEM_AW = 12;
    localparam int SPM_AW = 6;
    localparam int LEN_W  = 5;
    localparam int TBL_AW = 3;

    localparam int TBL_DEPTH = 1 << TBL_AW;
    localparam int SPM_DEPTH = 1 << SPM_AW;

    typedef logic [MEM_AW-1:0] mem_addr_t;
    typedef logic [SPM_AW-1:0] spm_addr_t;
    typedef logic [LEN_W-1:0]  blk_len_t;
    typedef logic [TBL_AW-1:0] tbl_idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        mem_addr_t src;
        spm_addr_t dst;
        blk_len_t  len;
        logic      last;
    } blk_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } seq_state_t;

    function automatic logic desc_is_empty(input blk_desc_t d);
        return d.len == '0;
    endfunction

    function automatic tbl_idx_t next_idx(input tbl_idx_t i);
        return i + tbl_idx_t'(1);
    endfunction

endpackage

// File: rtl/isc_desc_table.sv
module isc_desc_table
    import isc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  tbl_idx_t  wr_idx,
    input  blk_desc_t wr_desc,
    input  tbl_idx_t  rd_idx,
    output blk_desc_t rd_desc
);

    blk_desc_t slots [TBL_DEPTH];

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == tbl_idx_t'(g))) begin
                slots[g] <= wr_desc;
            end
        end
    end

    assign rd_desc = slots[rd_idx];

endmodule

// File: rtl/isc_cursor.sv
module isc_cursor
    import isc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      advance,
    input  blk_desc_t desc,
    output mem_addr_t src,
    output spm_addr_t dst,
    output logic      final_word,
    output logic      last_blk
);

    blk_len_t remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            src      <= '0;
            dst      <= '0;
            remain   <= '0;
            last_blk <= 1'b0;
        end else if (load) begin
            src      <= desc.src;
            dst      <= desc.dst;
            remain   <= desc.len;
            last_blk <= desc.last;
        end else if (advance) begin
            src    <= src + mem_addr_t'(1);
            dst    <= dst + spm_addr_t'(1);
            remain <= remain - blk_len_t'(1);
        end
    end

    assign final_word = (remain == blk_len_t'(1));

endmodule

// File: rtl/isc_seq_fsm.sv
module isc_seq_fsm
    import isc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  tbl_idx_t cmd_idx,
    input  logic     entry_empty,
    input  logic     entry_last,
    input  logic     final_word,
    input  logic     last_blk,
    input  logic     mem_req_ready,
    input  logic     mem_rsp_valid,
    output tbl_idx_t idx,
    output logic     load,
    output logic     advance,
    output logic     mem_req_valid,
    output logic     stall,
    output logic     done,
    output logic     idle,
    output logic     busy_err
);

    seq_state_t st, st_n;
    tbl_idx_t   idx_n;

    always_comb begin
        st_n          = st;
        idx_n         = idx;
        load          = 1'b0;
        advance       = 1'b0;
        mem_req_valid = 1'b0;
        case (st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    idx_n = cmd_idx;
                    st_n  = ST_ENTRY;
                end
            end
            ST_ENTRY: begin
                if (entry_empty) begin
                    if (entry_last) st_n = ST_FIN;
                    else            idx_n = next_idx(idx);
                end else begin
                    load = 1'b1;
                    st_n = ST_REQ;
                end
            end
            ST_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    advance = 1'b1;
                    if (final_word) begin
                        if (last_blk) begin
                            st_n = ST_FIN;
                        end else begin
                            idx_n = next_idx(idx);
                            st_n  = ST_ENTRY;
                        end
                    end else begin
                        st_n = ST_REQ;
                    end
                end
            end
            ST_FIN:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    assign stall = (st == ST_ENTRY) || (st == ST_REQ) || (st == ST_WAIT);
    assign done  = (st == ST_FIN);
    assign idle  = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst)                    busy_err <= 1'b0;
        else if (cmd_valid && !idle) busy_err <= 1'b1;
    end

endmodule

// File: rtl/ispm_copy_ctrl.sv
module ispm_copy_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [TBL_AW-1:0] cmd_idx,
    output logic              stall,
    output logic              done,
    output logic              busy_err,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_idx,
    input  logic [MEM_AW-1:0] tbl_src,
    input  logic [SPM_AW-1:0] tbl_dst,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic              tbl_last,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              spm_we,
    output logic [SPM_AW-1:0] spm_addr,
    output logic [DATA_W-1:0] spm_data
);

    blk_desc_t wr_desc, cur_desc;
    tbl_idx_t  walk_idx;
    logic      seq_idle, do_load, do_advance, final_word, last_blk;
    mem_addr_t cur_src;
    spm_addr_t cur_dst;

    assign wr_desc = '{src: tbl_src, dst: tbl_dst, len: tbl_len, last: tbl_last};

    isc_desc_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we && seq_idle),
        .wr_idx  (tbl_idx),
        .wr_desc (wr_desc),
        .rd_idx  (walk_idx),
        .rd_desc (cur_desc)
    );

    isc_cursor u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (do_load),
        .advance    (do_advance),
        .desc       (cur_desc),
        .src        (cur_src),
        .dst        (cur_dst),
        .final_word (final_word),
        .last_blk   (last_blk)
    );

    isc_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_idx       (cmd_idx),
        .entry_empty   (desc_is_empty(cur_desc)),
        .entry_last    (cur_desc.last),
        .final_word    (final_word),
        .last_blk      (last_blk),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .idx           (walk_idx),
        .load          (do_load),
        .advance       (do_advance),
        .mem_req_valid (mem_req_valid),
        .stall         (stall),
        .done          (done),
        .idle          (seq_idle),
        .busy_err      (busy_err)
    );

    assign mem_req_addr = cur_src;
    assign spm_we       = do_advance;
    assign spm_addr     = cur_dst;
    assign spm_data     = mem_rsp_data;

endmodule

// File: rtl/ispm_copy_chk.sv
module ispm_copy_chk
    import isc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              stall,
    input logic              done,
    input logic              busy_err,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MEM_AW-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              spm_we
);

    logic rd_open;

    always_ff @(posedge clk) begin
        if (rst)                                 rd_open <= 1'b0;
        else if (mem_req_valid && mem_req_ready) rd_open <= 1'b1;
        else if (mem_rsp_valid)                  rd_open <= 1'b0;
    end

    // R1
    cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !stall && !done |=> stall);

    // R4
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_open);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4
    wr_on_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        spm_we |-> mem_rsp_valid);

    // R5
    traffic_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || spm_we) |-> stall);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> done);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> busy_err);

    // R9
    busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (stall || done) |=> busy_err);

endmodule

bind ispm_copy_ctrl ispm_copy_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .stall         (stall),
    .done          (done),
    .busy_err      (busy_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .spm_we        (spm_we)
);

// File: tb/ispm_copy_ctrl_test.sv
module ispm_copy_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_idx = '0;
    logic        stall, done, busy_err;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [11:0] tbl_src = '0;
    logic [5:0]  tbl_dst = '0;
    logic [4:0]  tbl_len = '0;
    logic        tbl_last = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [11:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic        spm_we;
    logic [5:0]  spm_addr;
    logic [15:0] spm_data;

    int checks = 0;
    int errors = 0;

    int t_src [8];
    int t_dst [8];
    int t_len [8];
    bit t_last [8];
    logic [15:0] spm_model [64];

    bit          lat_mode = 1'b0;
    bit          pend = 1'b0;
    logic [11:0] paddr = '0;
    int          wcnt = 0;
    int          reqs = 0;
    int          cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ispm_copy_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .stall(stall), .done(done), .busy_err(busy_err),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_src(tbl_src), .tbl_dst(tbl_dst),
        .tbl_len(tbl_len), .tbl_last(tbl_last),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .spm_we(spm_we), .spm_addr(spm_addr), .spm_data(spm_data)
    );

    function automatic logic [15:0] fword(input int a);
        return 16'((a * 37 + 4660) & 16'hFFFF);
    endfunction

    // memory model: answers each accepted read once, after 0..3 extra cycles
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (wcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = fword(int'(paddr));
                pend = 1'b0;
            end else begin
                wcnt--;
            end
        end
        mem_req_ready = lat_mode ? 1'(((cyc % 2) ^ ((cyc / 4) % 2)) != 0) : 1'b1;
        if (!rst && mem_req_valid === 1'b1 && mem_req_ready) begin
            pend  = 1'b1;
            paddr = mem_req_addr;
            wcnt  = lat_mode ? int'(paddr % 4) : 0;
            reqs++;
        end
    end

    // scratchpad model
    always @(negedge clk) begin
        #1;
        if (spm_we === 1'b1) spm_model[spm_addr] = spm_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic prog(input int i, input int s, input int d, input int l, input bit lst);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 3'(i); tbl_src = 12'(s); tbl_dst = 6'(d);
        tbl_len = 5'(l); tbl_last = lst;
        @(negedge clk);
        tbl_we = 1'b0;
        t_src[i] = s; t_dst[i] = d; t_len[i] = l; t_last[i] = lst;
    endtask

    task automatic run_cmd(input int idx, input bit mode, input bit poke);
        logic [15:0] exp_mem [64];
        int i, words, exp_stall, scyc, bad, first_bad;
        lat_mode = mode;
        for (int k = 0; k < 64; k++) exp_mem[k] = spm_model[k];
        i = idx; words = 0; exp_stall = 0;
        for (int guard = 0; guard < 8; guard++) begin
            for (int k = 0; k < t_len[i]; k++)
                exp_mem[(t_dst[i] + k) % 64] = fword((t_src[i] + k) % 4096);
            words += t_len[i];
            exp_stall += 1 + 2 * t_len[i];
            if (t_last[i]) break;
            i = (i + 1) % 8;
        end
        @(negedge clk);
        reqs = 0;
        cmd_valid = 1'b1; cmd_idx = 3'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(stall === 1'b1, "R1", "stall after command", int'(stall), 1);
        scyc = 0;
        while (stall === 1'b1 && scyc < 4000) begin
            scyc++;
            if (poke && scyc == 3) begin
                // R9 busy command, R8 busy table write
                cmd_valid = 1'b1; cmd_idx = 3'(idx + 1);
                tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_src = 12'hABC;
                tbl_dst = 6'd1; tbl_len = 5'd7; tbl_last = 1'b1;
            end else begin
                cmd_valid = 1'b0; tbl_we = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0; tbl_we = 1'b0;
        check(done === 1'b1, "R7", "done when stall falls", int'(done), 1);
        if (!mode) check(scyc == exp_stall, "R5", "stall cycle count", scyc, exp_stall);
        @(negedge clk);
        check(done === 1'b0, "R7", "done lasts one cycle", int'(done), 0);
        #2;
        bad = 0; first_bad = -1;
        for (int k = 0; k < 64; k++)
            if (spm_model[k] !== exp_mem[k]) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        check(bad == 0, "R3", $sformatf("scratchpad contents idx %0d (first bad word %0d)", idx, first_bad), bad, 0);
        check(reqs == words, "R6", $sformatf("read count idx %0d (zero-length skips)", idx), reqs, words);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) spm_model[k] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(stall === 1'b0, "R10", "stall in reset", int'(stall), 0);
        check(done === 1'b0, "R10", "done in reset", int'(done), 0);
        check(busy_err === 1'b0, "R10", "busy_err in reset", int'(busy_err), 0);
        check(mem_req_valid === 1'b0, "R10", "request in reset", int'(mem_req_valid), 0);
        check(spm_we === 1'b0, "R10", "write in reset", int'(spm_we), 0);
        rst = 1'b0;
        @(negedge clk);
        check(stall === 1'b0 && done === 1'b0, "R10", "idle after reset", int'(stall), 0);

        // R2 table: chains, skips, wrap of index and scratchpad offset
        prog(0, 100, 0, 4, 0);
        prog(1, 200, 4, 0, 0);
        prog(2, 300, 10, 3, 1);
        prog(3, 400, 20, 0, 1);
        prog(4, 4090, 60, 8, 0);
        prog(5, 50, 30, 31, 1);
        prog(6, 700, 40, 2, 0);
        prog(7, 800, 45, 5, 0);

        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 8; s++)
                run_cmd(s, 1'(m), 1'b0);

        check(busy_err === 1'b0, "R9", "no error before busy command", int'(busy_err), 0);
        run_cmd(0, 1'b0, 1'b1);
        check(busy_err === 1'b1, "R9", "error after busy command", int'(busy_err), 1);
        // R8 entry 0 must still hold its old descriptor
        run_cmd(0, 1'b1, 1'b0);
        check(busy_err === 1'b1, "R9", "error stays set", int'(busy_err), 1);

        // R8 idle write takes effect; R6 former zero-length end entry now copies
        prog(3, 900, 50, 2, 1);
        run_cmd(3, 1'b0, 1'b0);
        run_cmd(2, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule